// File: doc/BRIEF.md
# ADC Conversion Sequencer with Clock Prescaler

This block sets the timing of an 8-bit analog-to-digital conversion. It builds a converter tick from one of two sources: every bus clock cycle, or a single-cycle enable that marks each edge of a crystal-derived clock. A free-running prescaler then divides the chosen source by a power of two. Each conversion runs for a fixed number of converter ticks. At the end the block saturates a signed code from a behavioural comparator model to the 8-bit range, latches it, and raises a completion flag.

Software starts a conversion just by writing the control register, modelled here as a one-cycle write strobe. The prescaler is not reset by that write, so the first converter period after the write is partial. Completion therefore falls between 16 and 17 full converter periods after the start. A second write in the middle of a conversion abandons it and starts the count again. When continuous mode is set, the block starts the next conversion by itself as each one ends.

Top module: `adc_seq_top`

## Requirements
- R1: A cycle with `ctlWr` high starts a conversion, and `convBusy` is high in the following cycle.
- R2: The result is latched on the 17th converter tick that occurs after the write cycle. A tick in the write cycle itself does not count. With the bus source and divide-by-1, `doneFlag` rises exactly 17 clock edges after the write edge.
- R3: With `cfgSrcSel` = 0, each bus cycle is a source tick. With `cfgSrcSel` = 1, only cycles with `xtalEn` high are source ticks. With no `xtalEn` pulses, a conversion never completes and stays busy.
- R4: `cfgDiv` codes 0, 1, 2, 3 and 4 divide the source by 1, 2, 4, 8 and 16. With the bus source and divide N, the write-to-flag latency is between 16N+1 and 17N edges.
- R5: The reserved `cfgDiv` codes 5, 6 and 7 divide by 16.
- R6: `anaIn` is two's complement. At the latching edge, a value at or below 0 gives 8'h00, a value at or above 255 gives 8'hFF, and a value in between is passed through unchanged.
- R7: `doneFlag` sets on the latching edge. It clears on the edge of a cycle with `resRd` high. If a latch and a read fall on the same edge, the flag ends up set.
- R8: A write during a conversion abandons it, and the 17-tick count restarts from that write.
- R9: A write with `ctlCont` = 1 selects continuous mode. In this mode each latch starts the next conversion at once, so with the bus source and divide-by-1, completions are 17 edges apart.
- R10: After reset, `convBusy`, `doneFlag` and `resData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| xtalEn | input | 1 | One-cycle enable that marks each edge of the crystal-derived clock |
| cfgSrcSel | input | 1 | Converter source select: 0 = bus clock, 1 = crystal enable |
| cfgDiv | input | 3 | Prescaler code: 0 to 4 divide by 2^code; 5 to 7 divide by 16 |
| ctlWr | input | 1 | Control register write strobe; starts a conversion |
| ctlCont | input | 1 | Continuous-mode bit, taken on each write |
| resRd | input | 1 | Result register read strobe; clears the flag |
| anaIn | input | IN_W | Signed code from the comparator model |
| resData | output | RES_W | Latched, saturated result |
| doneFlag | output | 1 | Conversion complete flag |
| convBusy | output | 1 | A conversion is in progress |

## Verification
The bench builds the block with its default parameters: a 10-bit signed input, an 8-bit result, a 17-tick conversion and a 4-bit prescaler. That input width is two bits wider than the result, so both negative codes and codes above full scale reach the saturation logic. The 4-bit prescaler lets every divide code, including the reserved ones, be measured against its latency window within a few hundred cycles. Divide-by-1 on the bus source removes the phase uncertainty. This gives exact edge counts for the restart, continuous-mode and same-edge latch-and-read cases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Strobes from the sequencing control to the result datapath
  typedef struct packed {
    logic latchRes;   // final converter tick of a conversion
  } seq_strobe_t;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

endpackage

// File: rtl/adc_seq_clkgen.sv
module adc_seq_clkgen #(
  parameter int MAX_LOG = 4,
  parameter int CODE_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xtalEn,
  input  logic              srcSel,
  input  logic [CODE_W-1:0] divCode,
  output logic              convTick
);
  localparam int CNT_W = MAX_LOG;

  logic             srcTick;
  logic [CNT_W-1:0] preCnt;
  logic [CNT_W-1:0] divMask;
  logic [CODE_W-1:0] logDiv;

  assign srcTick = srcSel ? xtalEn : 1'b1;

  // Codes past the largest ratio fall back to that largest ratio
  always_comb begin
    if (32'(divCode) > MAX_LOG) logDiv = CODE_W'(MAX_LOG);
    else                        logDiv = divCode;
    divMask = (CNT_W'(1) << logDiv) - CNT_W'(1);
  end

  assign convTick = srcTick && ((preCnt & divMask) == divMask);

  // The prescaler runs freely and a conversion start does not clear it
  always_ff @(posedge clk) begin
    if (!rstN)        preCnt <= '0;
    else if (srcTick) preCnt <= preCnt + CNT_W'(1);
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CONV_TICKS = 17
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        convTick,
  input  logic        ctlWr,
  input  logic        ctlCont,
  output logic        convBusy,
  output seq_strobe_t strb
);
  localparam int CNT_W = $clog2(CONV_TICKS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CONV_TICKS - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] tickCnt;
  logic             contMode;

  assign convBusy = (state == SEQ_RUN);

  // A write in the same cycle wins over the final tick
  always_comb begin
    strb          = '0;
    strb.latchRes = convBusy && convTick && (tickCnt == LAST_IDX) && !ctlWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      tickCnt  <= '0;
      contMode <= 1'b0;
    end else if (ctlWr) begin
      state    <= SEQ_RUN;
      tickCnt  <= '0;
      contMode <= ctlCont;
    end else if (convBusy && convTick) begin
      if (tickCnt == LAST_IDX) begin
        tickCnt <= '0;
        state   <= contMode ? SEQ_RUN : SEQ_IDLE;
      end else begin
        tickCnt <= tickCnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
#(
  parameter int IN_W  = 10,
  parameter int RES_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seq_strobe_t            strb,
  input  logic                   resRd,
  input  logic signed [IN_W-1:0] anaIn,
  output logic [RES_W-1:0]       resData,
  output logic                   doneFlag
);
  localparam logic signed [IN_W:0] FULL_SCALE = (IN_W+1)'((1 << RES_W) - 1);

  logic signed [IN_W:0] inExt;
  logic [RES_W-1:0]     satCode;

  assign inExt = {anaIn[IN_W-1], anaIn};

  always_comb begin
    if (inExt <= 0)                satCode = '0;
    else if (inExt >= FULL_SCALE)  satCode = '1;
    else                           satCode = inExt[RES_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resData  <= '0;
      doneFlag <= 1'b0;
    end else begin
      if (strb.latchRes) resData <= satCode;
      // Setting wins over a read on the same edge
      if (strb.latchRes) doneFlag <= 1'b1;
      else if (resRd)    doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int IN_W       = 10,
  parameter int RES_W      = 8,
  parameter int CONV_TICKS = 17,
  parameter int MAX_LOG    = 4,
  parameter int CODE_W     = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   xtalEn,
  input  logic                   cfgSrcSel,
  input  logic [CODE_W-1:0]      cfgDiv,
  input  logic                   ctlWr,
  input  logic                   ctlCont,
  input  logic                   resRd,
  input  logic signed [IN_W-1:0] anaIn,
  output logic [RES_W-1:0]       resData,
  output logic                   doneFlag,
  output logic                   convBusy
);
  logic        convTick;
  seq_strobe_t strb;

  adc_seq_clkgen #(.MAX_LOG(MAX_LOG), .CODE_W(CODE_W)) u_clkgen (
    .clk(clk), .rstN(rstN), .xtalEn(xtalEn), .srcSel(cfgSrcSel),
    .divCode(cfgDiv), .convTick(convTick)
  );

  adc_seq_ctrl #(.CONV_TICKS(CONV_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .convTick(convTick), .ctlWr(ctlWr),
    .ctlCont(ctlCont), .convBusy(convBusy), .strb(strb)
  );

  adc_seq_dpath #(.IN_W(IN_W), .RES_W(RES_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .resRd(resRd), .anaIn(anaIn),
    .resData(resData), .doneFlag(doneFlag)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int IN_W  = 10,
  parameter int RES_W = 8
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   ctlWr,
  input logic                   resRd,
  input logic signed [IN_W-1:0] anaIn,
  input logic [RES_W-1:0]       resData,
  input logic                   doneFlag,
  input logic                   convBusy,
  input logic                   latchRes
);
  localparam logic signed [IN_W:0] FULL_SCALE = (IN_W+1)'((1 << RES_W) - 1);

  logic signed [IN_W:0] inExt;
  assign inExt = {anaIn[IN_W-1], anaIn};

  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWr |=> convBusy);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchRes |=> doneFlag);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resRd && !latchRes) |=> !doneFlag);

  // R6
  sat_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchRes && (inExt >= FULL_SCALE)) |=> (resData == '1));

  // R6
  sat_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchRes && (inExt <= 0)) |=> (resData == '0));

  // R2
  done_from_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(convBusy));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !latchRes |=> $stable(resData));
endmodule

bind adc_seq_top adc_seq_chk #(.IN_W(IN_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .resRd(resRd), .anaIn(anaIn),
  .resData(resData), .doneFlag(doneFlag), .convBusy(convBusy),
  .latchRes(strb.latchRes)
);

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              xtalEn = 1'b0;
  logic              cfgSrcSel = 1'b0;
  logic [2:0]        cfgDiv = 3'd0;
  logic              ctlWr = 1'b0;
  logic              ctlCont = 1'b0;
  logic              resRd = 1'b0;
  logic signed [9:0] anaIn = '0;
  logic [7:0]        resData;
  logic              doneFlag;
  logic              convBusy;

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  logic xtalRun = 1'b0;
  int xtalPh = 0;

  always #2 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  // Crystal enable: one pulse every third cycle while running
  always @(negedge clk) begin
    if (xtalRun) begin
      xtalPh <= (xtalPh == 2) ? 0 : xtalPh + 1;
      xtalEn <= (xtalPh == 2);
    end else begin
      xtalEn <= 1'b0;
    end
  end

  adc_seq_top u_dut (
    .clk(clk), .rstN(rstN), .xtalEn(xtalEn), .cfgSrcSel(cfgSrcSel),
    .cfgDiv(cfgDiv), .ctlWr(ctlWr), .ctlCont(ctlCont), .resRd(resRd),
    .anaIn(anaIn), .resData(resData), .doneFlag(doneFlag), .convBusy(convBusy)
  );

  typedef struct packed {
    logic [2:0]        div;
    logic signed [9:0] ana;
    logic [7:0]        res;
    logic [15:0]       lmin;
    logic [15:0]       lmax;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd0, 10'sd100,  8'd100, 16'd17,  16'd17},
    '{3'd1, -10'sd5,   8'd0,   16'd33,  16'd34},
    '{3'd2, 10'sd300,  8'd255, 16'd65,  16'd68},
    '{3'd3, 10'sd255,  8'd255, 16'd129, 16'd136},
    '{3'd4, 10'sd0,    8'd0,   16'd257, 16'd272},
    '{3'd6, 10'sd128,  8'd128, 16'd257, 16'd272}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic startConv(input logic cont, output int t0);
    @(negedge clk);
    ctlWr = 1'b1;
    ctlCont = cont;
    @(negedge clk);
    ctlWr = 1'b0;
    t0 = edgeCnt;
  endtask

  task automatic waitDone(input int t0, output int lat);
    lat = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (doneFlag) begin
        lat = edgeCnt - t0;
        break;
      end
    end
  endtask

  task automatic readRes();
    @(negedge clk);
    resRd = 1'b1;
    @(negedge clk);
    resRd = 1'b0;
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, lat;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(convBusy == 1'b0, "R10 busy", convBusy, 0);
    check(doneFlag == 1'b0, "R10 flag", doneFlag, 0);
    check(resData == 8'd0, "R10 result", resData, 0);

    // Table: R4/R5 latency, R6 saturation, R7 set and clear
    for (int v = 0; v < 6; v++) begin
      cfgDiv = VEC[v].div;
      anaIn = VEC[v].ana;
      startConv(1'b0, t0);
      check(convBusy == 1'b1, "R1 busy after write", convBusy, 1);
      waitDone(t0, lat);
      check(lat >= int'(VEC[v].lmin) && lat <= int'(VEC[v].lmax),
            (VEC[v].div > 4) ? "R5 reserved divide latency" : "R4 divide latency",
            lat, int'(VEC[v].lmin));
      check(resData == VEC[v].res, "R6 saturated result", resData, VEC[v].res);
      readRes();
      check(doneFlag == 1'b0, "R7 flag clears on read", doneFlag, 0);
    end

    // R2 exact latency with divide-by-1
    cfgDiv = 3'd0;
    anaIn = 10'sd77;
    startConv(1'b0, t0);
    waitDone(t0, lat);
    check(lat == 17, "R2 exact latency", lat, 17);
    check(convBusy == 1'b0, "R2 idle after single conversion", convBusy, 0);
    readRes();

    // R8 restart by a second write
    startConv(1'b0, t0);
    repeat (8) @(negedge clk);
    check(doneFlag == 1'b0, "R8 no flag mid conversion", doneFlag, 0);
    startConv(1'b0, t1);
    waitDone(t1, lat);
    check(lat == 17, "R8 restarted latency", lat, 17);
    readRes();

    // R7 latch and read on the same edge: flag stays set
    startConv(1'b0, t0);
    repeat (16) @(negedge clk);
    resRd = 1'b1;
    @(negedge clk);
    resRd = 1'b0;
    check(doneFlag == 1'b1, "R7 set wins over read", doneFlag, 1);
    readRes();

    // R9 continuous mode
    anaIn = 10'sd5;
    startConv(1'b1, t0);
    waitDone(t0, lat);
    check(lat == 17, "R9 first continuous latency", lat, 17);
    t1 = edgeCnt;
    readRes();
    check(doneFlag == 1'b0, "R9 flag cleared between runs", doneFlag, 0);
    check(convBusy == 1'b1, "R9 busy continues", convBusy, 1);
    waitDone(t1, lat);
    check(lat == 17, "R9 repeat spacing", lat, 17);
    check(resData == 8'd5, "R9 repeat result", resData, 5);
    startConv(1'b0, t0);
    waitDone(t0, lat);
    readRes();

    // R3 crystal source with no pulses never completes
    cfgSrcSel = 1'b1;
    startConv(1'b0, t0);
    repeat (60) @(negedge clk);
    check(doneFlag == 1'b0, "R3 no crystal pulses no flag", doneFlag, 0);
    check(convBusy == 1'b1, "R3 stays busy", convBusy, 1);

    // R3 crystal pulses every third cycle
    xtalRun = 1'b1;
    repeat (3) @(negedge clk);
    startConv(1'b0, t0);
    waitDone(t0, lat);
    check(lat >= 49 && lat <= 51, "R3 crystal source latency", lat, 49);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule